// File: doc/BRIEF.md
# Calendar Real-Time Clock with Deferred Write Commit

This block is the counting core of a real-time clock. It holds seconds, minutes, hours, day of month, month and a year offset. The counters step once for every one-cycle `tick_i` pulse, which arrives from a slow one-second source. Software reaches the block through a small register bus. A write takes effect in the same cycle, and a read returns its data combinationally for the address on the bus. The block has three words: a control word at offset 0x0, a packed date word at 0x4 and a packed time word at 0x8. The date and time words show the running counters, so two reads in a row can return different values.

A write to the time word or to the date word is not applied at once. The value is held in a pending register, and a busy bit for that word is raised in the control word. On the second tick after the write, the pending value replaces the running counters and the busy bit drops. Each word has its own commit sequencer with three states: `CM_IDLE`, `CM_ARMED` and `CM_HALF`.
- `CM_IDLE` goes to `CM_ARMED` on a write to the word. This transition is the only point where a write is accepted.
- `CM_ARMED` goes to `CM_HALF` on a tick.
- `CM_HALF` goes back to `CM_IDLE` on a tick. This is the commit tick, in which the pending value is loaded.
- A write that arrives outside `CM_IDLE` is dropped.

The parameter `YEAR_WIDE` picks the year field. At 0 the field is 6 bits wide and the leap flag sits at bit 22. At 1 the field is 8 bits wide and the leap flag sits at bit 24.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the control word reads 0, the time word reads 0 (00:00:00) and the date word reads 0x00000101 (day 1, month 1, year offset 0, leap flag 0).
- R2: The time word is read and written at offset 0x8. Seconds are in bits [5:0], minutes in bits [13:8] and hours in bits [20:16]. All other bits read 0.
- R3: The date word is read and written at offset 0x4. The day is in bits [4:0], the month in bits [11:8] and the year offset starts at bit 16, with a width of 6 bits (or 8 when `YEAR_WIDE`=1). The leap flag sits at bit 22 (or bit 24). All other bits read 0.
- R4: A time write sets bit 8 of the control word (offset 0x0) from the next cycle. The bit stays set until the second tick after the write. On that tick's clock edge the written time is loaded and the bit clears.
- R5: A date write sets bit 7 of the control word and commits in the same way as a time write, independently of it.
- R6: A write to the time word or the date word while that word's busy bit is set has no effect. The first written value is the one committed.
- R7: The time and date words change only on a clock edge where `tick_i` is high.
- R8: On a tick, seconds count up and wrap from 59 to 0 with a carry into minutes. Minutes wrap from 59 to 0 with a carry into hours. Hours wrap from 23 to 0 with a carry that advances the day.
- R9: When the day advances past the last day of the month, it wraps to 1 and the month steps up. Months 4, 6, 9 and 11 have 30 days. Months 1, 3, 5, 7, 8, 10 and 12 have 31 days.
- R10: February has 29 days when the leap flag is 1 and 28 days when it is 0. Counting never changes the leap flag.
- R11: When the day wraps in month 12, the month becomes 1 and the year offset steps up by one. The year offset wraps to 0 when it is at its largest value.
- R12: On a commit tick, the committed word takes the written value and does not advance. A time commit produces no day carry. A date commit replaces any day carry produced by the time word on that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and counter clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse, once per second |
| bus_we_i | input | 1 | Write strobe for the register bus |
| bus_addr_i | input | ADDR_W (4) | Byte offset of the word |
| bus_wdata_i | input | DATA_W (32) | Write data |
| bus_rdata_o | output | DATA_W (32) | Read data for `bus_addr_i`, combinational |

## Verification
Two situations are hard to reach from the ports. The first is a date commit that lands on the same tick as a midnight carry from the time word. The second is the second leap-year February step, from the 29th to March 1st. For the first case, the bench commits 23:59:58 to the time word and then writes the date. The second tick after the write is then both the date commit and the rollover of the time word. For the leap case, the bench re-commits 23:59:59 to the time word on its own, so the date is left on the 29th while the time is set back up. Bus writes, reads and tick pulses are all placed on separate falling edges, so the commit tick can be counted exactly.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    // time word field positions
    localparam int SEC_LSB  = 0;
    localparam int MIN_LSB  = 8;
    localparam int HR_LSB   = 16;
    // date word field positions
    localparam int DAY_LSB  = 0;
    localparam int MON_LSB  = 8;
    localparam int YEAR_LSB = 16;
    // control word busy bits
    localparam int TBUSY_BIT = 8;
    localparam int DBUSY_BIT = 7;
    // register offsets
    localparam int OFF_CTRL = 0;
    localparam int OFF_DATE = 4;
    localparam int OFF_TIME = 8;

    typedef struct packed {
        logic [4:0] hr;
        logic [5:0] mn;
        logic [5:0] sc;
    } hms_t;

    typedef enum logic [1:0] {
        CM_IDLE  = 2'd0,
        CM_ARMED = 2'd1,
        CM_HALF  = 2'd2
    } cm_state_e;

    function automatic logic [4:0] month_days(input logic [3:0] mon, input logic leap);
        logic [4:0] d;
        case (mon)
            4'd4, 4'd6, 4'd9, 4'd11: d = 5'd30;
            4'd2:                    d = leap ? 5'd29 : 5'd28;
            default:                 d = 5'd31;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/rtc_commit_fsm.sv
module rtc_commit_fsm
    import rtc_cal_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic req_i,
    output logic busy_o,
    output logic load_o
);

    cm_state_e state_q, state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= CM_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CM_IDLE:  if (req_i)  state_d = CM_ARMED;
            CM_ARMED: if (tick_i) state_d = CM_HALF;
            CM_HALF:  if (tick_i) state_d = CM_IDLE;
            default:              state_d = CM_IDLE;
        endcase
    end

    always_comb begin
        busy_o = (state_q != CM_IDLE);
        load_o = (state_q == CM_HALF) && tick_i;
    end

endmodule

// File: rtl/rtc_hms_counter.sv
module rtc_hms_counter
    import rtc_cal_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic load_i,
    input  hms_t load_val_i,
    output hms_t now_o,
    output logic day_carry_o
);

    hms_t now_q;
    logic sc_wrap, mn_wrap, hr_wrap;

    always_comb begin
        sc_wrap     = (now_q.sc >= 6'd59);
        mn_wrap     = (now_q.mn >= 6'd59);
        hr_wrap     = (now_q.hr >= 5'd23);
        day_carry_o = tick_i && !load_i && sc_wrap && mn_wrap && hr_wrap;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            now_q <= '0;
        end else if (load_i) begin
            now_q <= load_val_i;
        end else if (tick_i) begin
            if (!sc_wrap) begin
                now_q.sc <= now_q.sc + 6'd1;
            end else begin
                now_q.sc <= '0;
                if (!mn_wrap) begin
                    now_q.mn <= now_q.mn + 6'd1;
                end else begin
                    now_q.mn <= '0;
                    now_q.hr <= hr_wrap ? 5'd0 : now_q.hr + 5'd1;
                end
            end
        end
    end

    assign now_o = now_q;

endmodule

// File: rtl/rtc_date_counter.sv
module rtc_date_counter
    import rtc_cal_pkg::*;
#(
    parameter int YEAR_W = 6
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              day_inc_i,
    input  logic              load_i,
    input  logic [4:0]        ld_day_i,
    input  logic [3:0]        ld_mon_i,
    input  logic [YEAR_W-1:0] ld_year_i,
    input  logic              ld_leap_i,
    output logic [4:0]        day_o,
    output logic [3:0]        mon_o,
    output logic [YEAR_W-1:0] year_o,
    output logic              leap_o
);

    logic [4:0]        day_q;
    logic [3:0]        mon_q;
    logic [YEAR_W-1:0] year_q;
    logic              leap_q;
    logic [4:0]        last_day;

    always_comb last_day = month_days(mon_q, leap_q);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            day_q  <= 5'd1;
            mon_q  <= 4'd1;
            year_q <= '0;
            leap_q <= 1'b0;
        end else if (load_i) begin
            day_q  <= ld_day_i;
            mon_q  <= ld_mon_i;
            year_q <= ld_year_i;
            leap_q <= ld_leap_i;
        end else if (day_inc_i) begin
            if (day_q >= last_day) begin
                day_q <= 5'd1;
                if (mon_q >= 4'd12) begin
                    mon_q  <= 4'd1;
                    year_q <= year_q + 1'b1;
                end else begin
                    mon_q <= mon_q + 4'd1;
                end
            end else begin
                day_q <= day_q + 5'd1;
            end
        end
    end

    assign day_o  = day_q;
    assign mon_o  = mon_q;
    assign year_o = year_q;
    assign leap_o = leap_q;

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_cal_pkg::*;
#(
    parameter bit YEAR_WIDE = 1'b0,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o
);

    localparam int YEAR_W   = YEAR_WIDE ? 8 : 6;
    localparam int LEAP_POS = YEAR_LSB + YEAR_W;

    logic time_sel, date_sel, ctrl_sel;
    logic time_busy, date_busy, time_load, date_load;
    logic time_req, date_req, day_carry;

    hms_t              time_pend, time_now;
    logic [4:0]        pend_day, cur_day;
    logic [3:0]        pend_mon, cur_mon;
    logic [YEAR_W-1:0] pend_year, cur_year;
    logic              pend_leap, cur_leap;

    logic [DATA_W-1:0] time_word, date_word, ctrl_word;

    always_comb begin
        ctrl_sel = (bus_addr_i == ADDR_W'(OFF_CTRL));
        date_sel = (bus_addr_i == ADDR_W'(OFF_DATE));
        time_sel = (bus_addr_i == ADDR_W'(OFF_TIME));
        time_req = bus_we_i && time_sel;
        date_req = bus_we_i && date_sel;
    end

    rtc_commit_fsm u_time_cm (
        .clk_i (clk_i), .rst_ni (rst_ni), .tick_i (tick_i),
        .req_i (time_req), .busy_o (time_busy), .load_o (time_load)
    );

    rtc_commit_fsm u_date_cm (
        .clk_i (clk_i), .rst_ni (rst_ni), .tick_i (tick_i),
        .req_i (date_req), .busy_o (date_busy), .load_o (date_load)
    );

    // pending values are captured only when the sequencer accepts the write
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            time_pend <= '0;
            pend_day  <= 5'd1;
            pend_mon  <= 4'd1;
            pend_year <= '0;
            pend_leap <= 1'b0;
        end else begin
            if (time_req && !time_busy) begin
                time_pend.sc <= bus_wdata_i[SEC_LSB +: 6];
                time_pend.mn <= bus_wdata_i[MIN_LSB +: 6];
                time_pend.hr <= bus_wdata_i[HR_LSB  +: 5];
            end
            if (date_req && !date_busy) begin
                pend_day  <= bus_wdata_i[DAY_LSB  +: 5];
                pend_mon  <= bus_wdata_i[MON_LSB  +: 4];
                pend_year <= bus_wdata_i[YEAR_LSB +: YEAR_W];
                pend_leap <= bus_wdata_i[LEAP_POS];
            end
        end
    end

    rtc_hms_counter u_hms (
        .clk_i (clk_i), .rst_ni (rst_ni), .tick_i (tick_i),
        .load_i (time_load), .load_val_i (time_pend),
        .now_o (time_now), .day_carry_o (day_carry)
    );

    rtc_date_counter #(.YEAR_W (YEAR_W)) u_date (
        .clk_i (clk_i), .rst_ni (rst_ni),
        .day_inc_i (day_carry), .load_i (date_load),
        .ld_day_i (pend_day), .ld_mon_i (pend_mon),
        .ld_year_i (pend_year), .ld_leap_i (pend_leap),
        .day_o (cur_day), .mon_o (cur_mon),
        .year_o (cur_year), .leap_o (cur_leap)
    );

    always_comb begin
        time_word = '0;
        time_word[SEC_LSB +: 6] = time_now.sc;
        time_word[MIN_LSB +: 6] = time_now.mn;
        time_word[HR_LSB  +: 5] = time_now.hr;

        date_word = '0;
        date_word[DAY_LSB  +: 5]      = cur_day;
        date_word[MON_LSB  +: 4]      = cur_mon;
        date_word[YEAR_LSB +: YEAR_W] = cur_year;
        date_word[LEAP_POS]           = cur_leap;

        ctrl_word = '0;
        ctrl_word[TBUSY_BIT] = time_busy;
        ctrl_word[DBUSY_BIT] = date_busy;

        if (ctrl_sel)      bus_rdata_o = ctrl_word;
        else if (date_sel) bus_rdata_o = date_word;
        else if (time_sel) bus_rdata_o = time_word;
        else               bus_rdata_o = '0;
    end

endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
    import rtc_cal_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              tick_i,
    input logic              bus_we_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic              time_busy,
    input logic              date_busy,
    input logic [DATA_W-1:0] time_word,
    input logic [DATA_W-1:0] date_word
);

    // R4
    time_busy_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_we_i && bus_addr_i == ADDR_W'(OFF_TIME) && !time_busy) |=> time_busy);

    // R4
    time_busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (time_busy && !tick_i) |=> time_busy);

    // R5
    date_busy_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_we_i && bus_addr_i == ADDR_W'(OFF_DATE) && !date_busy) |=> date_busy);

    // R5
    date_busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (date_busy && !tick_i) |=> date_busy);

    // R7
    time_still_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i |=> $stable(time_word));

    // R7
    date_still_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i |=> $stable(date_word));

    // R8
    sec_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !time_busy && time_word[SEC_LSB +: 6] == 6'd59)
        |=> (time_word[SEC_LSB +: 6] == 6'd0));

endmodule

bind rtc_calendar_core rtc_calendar_chk #(.ADDR_W (ADDR_W), .DATA_W (DATA_W)) u_chk (
    .clk_i (clk_i), .rst_ni (rst_ni), .tick_i (tick_i),
    .bus_we_i (bus_we_i), .bus_addr_i (bus_addr_i),
    .time_busy (time_busy), .date_busy (date_busy),
    .time_word (time_word), .date_word (date_word)
);

// File: tb/tb_rtc_calendar_core.sv
module tb_rtc_calendar_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        we = 1'b0;
    logic [3:0]  addr = 4'h0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    rtc_calendar_core dut (
        .clk_i (clk), .rst_ni (rst_n), .tick_i (tick),
        .bus_we_i (we), .bus_addr_i (addr),
        .bus_wdata_i (wdata), .bus_rdata_o (rdata)
    );

    function automatic logic [31:0] tw(input int h, input int m, input int s);
        return (32'(h) << 16) | (32'(m) << 8) | 32'(s);
    endfunction

    // 6-bit year at bit 16, leap flag at bit 22
    function automatic logic [31:0] dw(input int y, input int mo, input int d, input bit lp);
        return (32'(lp) << 22) | (32'(y) << 16) | (32'(mo) << 8) | 32'(d);
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); we = 1'b1; addr = a; wdata = d;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; #1; d = rdata;
    endtask

    task automatic pulse;
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic set_both(input logic [31:0] t, input logic [31:0] d);
        wr(4'h8, t); wr(4'h4, d); pulse(); pulse();
    endtask

    task automatic test_reset;
        logic [31:0] v;
        rd(4'h0, v); check("R1 ctrl", v, 32'h0);
        rd(4'h8, v); check("R1 time", v, 32'h0);
        rd(4'h4, v); check("R1 date", v, 32'h0000_0101);
    endtask

    task automatic test_time_commit;
        logic [31:0] v;
        wr(4'h8, tw(1, 2, 3));
        rd(4'h0, v); check("R4 busy after write", v, 32'h100);
        pulse();
        rd(4'h0, v); check("R4 busy after first tick", v, 32'h100);
        rd(4'h8, v); check("R4 time not yet applied", v, tw(0, 0, 1));
        pulse();
        rd(4'h0, v); check("R4 busy cleared", v, 32'h0);
        rd(4'h8, v); check("R2 time loaded", v, tw(1, 2, 3));
        pulse();
        rd(4'h8, v); check("R8 second step", v, tw(1, 2, 4));
    endtask

    task automatic test_ignore;
        logic [31:0] v;
        wr(4'h8, tw(5, 5, 5)); wr(4'h8, tw(9, 9, 9));
        wr(4'h4, dw(3, 4, 10, 0)); wr(4'h4, dw(7, 7, 7, 0));
        rd(4'h0, v); check("R5 date busy with time busy", v, 32'h180);
        pulse(); pulse();
        rd(4'h8, v); check("R6 time second write dropped", v, tw(5, 5, 5));
        rd(4'h4, v); check("R6 date second write dropped", v, dw(3, 4, 10, 0));
        rd(4'h0, v); check("R5 busy bits cleared", v, 32'h0);
        wr(4'h4, dw(1, 2, 3, 0));
        rd(4'h0, v); check("R5 date busy alone", v, 32'h080);
        pulse(); pulse();
        rd(4'h4, v); check("R3 date packing", v, dw(1, 2, 3, 0));
    endtask

    task automatic test_hold;
        logic [31:0] a, b;
        rd(4'h8, a);
        repeat (20) @(negedge clk);
        rd(4'h8, b); check("R7 time holds without tick", b, a);
    endtask

    task automatic test_rollover;
        logic [31:0] v;
        set_both(tw(0, 0, 59), dw(2, 4, 15, 0)); pulse();
        rd(4'h8, v); check("R8 seconds wrap", v, tw(0, 1, 0));
        set_both(tw(0, 59, 59), dw(2, 4, 15, 0)); pulse();
        rd(4'h8, v); check("R8 minutes wrap", v, tw(1, 0, 0));
        set_both(tw(23, 59, 59), dw(2, 4, 15, 0)); pulse();
        rd(4'h8, v); check("R8 hours wrap", v, 32'h0);
        rd(4'h4, v); check("R8 day carry", v, dw(2, 4, 16, 0));
    endtask

    task automatic day_step(input string req, input logic [31:0] din, input logic [31:0] dexp);
        logic [31:0] v;
        set_both(tw(23, 59, 59), din); pulse();
        rd(4'h4, v); check(req, v, dexp);
    endtask

    task automatic test_months;
        day_step("R9 30-day month end", dw(0, 4, 30, 0), dw(0, 5, 1, 0));
        day_step("R9 31-day month end", dw(0, 1, 31, 0), dw(0, 2, 1, 0));
        day_step("R9 30th of 31-day month", dw(0, 1, 30, 0), dw(0, 1, 31, 0));
    endtask

    task automatic test_feb;
        logic [31:0] v;
        day_step("R10 Feb 28 no leap", dw(4, 2, 28, 0), dw(4, 3, 1, 0));
        day_step("R10 Feb 28 leap", dw(4, 2, 28, 1), dw(4, 2, 29, 1));
        wr(4'h8, tw(23, 59, 59)); pulse(); pulse(); pulse();
        rd(4'h4, v); check("R10 Feb 29 leap end", v, dw(4, 3, 1, 1));
    endtask

    task automatic test_year;
        day_step("R11 year end", dw(5, 12, 31, 1), dw(6, 1, 1, 1));
        day_step("R11 year offset wrap", dw(63, 12, 31, 0), dw(0, 1, 1, 0));
    endtask

    task automatic test_commit_tick;
        logic [31:0] v;
        set_both(tw(23, 59, 59), dw(9, 6, 10, 0));
        rd(4'h8, v); check("R12 time loaded not advanced", v, tw(23, 59, 59));
        rd(4'h4, v); check("R12 no carry on time commit", v, dw(9, 6, 10, 0));
        wr(4'h8, tw(23, 59, 58)); pulse(); pulse();
        wr(4'h4, dw(9, 6, 20, 0)); pulse(); pulse();
        rd(4'h8, v); check("R12 time rolled on date commit", v, 32'h0);
        rd(4'h4, v); check("R12 date commit overrides carry", v, dw(9, 6, 20, 0));
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_time_commit();
        test_ignore();
        test_hold();
        test_rollover();
        test_months();
        test_feb();
        test_year();
        test_commit_tick();
        done = 1'b1;
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

endmodule